// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Pair

This block contains two independent monostable channels. Each one generates a single high pulse on its output `q`, and `q_n` always carries the inverse. A channel has three asynchronous controls. `trig_a_n` fires on a falling edge and `trig_b` fires on a rising edge. Each of these can hold the other off. The active-low `clr_n` resets the channel, and its release also counts as a trigger when the other two inputs are in their enabling levels. The pulse length comes from a per-channel word, `pulse_len`, measured in system clock cycles.

All three controls are synchronized with two flops. Edge detection compares each synchronized value with its value from the previous cycle. A channel runs a two-state machine:

- **IDLE**: the output is low.
- **PULSE**: the output is high, and a down-counter measures what is left of the pulse.

The machine has these transitions:

- **IDLE→PULSE** (fire): a valid trigger loads the counter.
- **PULSE→PULSE** (retrigger): a valid trigger reloads the counter with the full length.
- **PULSE→PULSE** (tick): with no trigger, the counter decrements.
- **PULSE→IDLE** (expire): the counter has reached zero and no trigger is present.
- **any→IDLE** (clear): `clr_n` is low.

Top module: `os_pair`

## Requirements
- R1: A falling edge on `trig_a_n` while `trig_b` is high fires the channel. `q` is first high when sampled after the third rising clock edge that follows the input change.
- R2: A rising edge on `trig_b` while `trig_a_n` is low fires the channel with the same three-edge latency as R1.
- R3: No other combination of before and after levels of the two trigger inputs fires the channel. This covers `trig_a_n` high blocking `trig_b`, `trig_b` low blocking `trig_a_n`, and opposite-polarity edges.
- R4: Driving `clr_n` low immediately forces `q` low and `q_n` high, without waiting for a clock edge, and ends any pulse in progress.
- R5: Trigger edges are ignored while `clr_n` is low, and `q` stays low.
- R6: A rising edge on `clr_n` fires the channel if `trig_a_n` is low and `trig_b` is high, with the three-edge latency of R1. If `trig_a_n` is high, the release does not fire.
- R7: A fired pulse keeps `q` high for exactly N clock cycles, where N is the value of `pulse_len`. A value of 0 is treated as 1.
- R8: A valid trigger during a pulse restarts the full length N. `q` stays high until N cycles after the last trigger has taken effect.
- R9: A change of `pulse_len` during a pulse leaves that pulse's length unchanged. The new value applies from the next trigger.
- R10: The channels are independent. Activity on one channel never moves the other channel's `q`.
- R11: `q_n` is the complement of `q` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| clr_n | input | NCH | Per-channel active-low clear; its rising edge can fire |
| trig_a_n | input | NCH | Per-channel falling-edge trigger input |
| trig_b | input | NCH | Per-channel rising-edge trigger input |
| pulse_len | input | NCH x CW | Per-channel pulse length in clock cycles |
| q | output | NCH | Per-channel pulse output |
| q_n | output | NCH | Per-channel complement of `q` |

## Verification
The bench builds the block with `CW = 4`, so the length sweep covers every code from 0 to 15 on both channels, including the zero-clamp case. With NCH left at 2, the bench also watches the idle channel during each sweep step. Every pairing of before and after levels on the two trigger inputs is applied, sixteen in all, and the expected firing is worked out from the edge rules. Retrigger timing, a length change in mid-pulse, an asynchronous clear during a pulse, triggers applied while clear is held, and firing from clear release are all timed to the exact cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
    typedef enum logic {
        OS_IDLE  = 1'b0,
        OS_PULSE = 1'b1
    } os_state_e;
endpackage

// File: rtl/os_sync.sv
// Two-flop synchronizer followed by a one-cycle history register.
module os_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta <= RST_VAL;
            cur  <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            meta <= d;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/os_fire_gate.sv
// Combines the synchronized levels and their previous values into one fire strobe.
module os_fire_gate (
    input  logic a_cur,
    input  logic a_prv,
    input  logic b_cur,
    input  logic b_prv,
    input  logic c_cur,
    input  logic c_prv,
    output logic fire
);
    logic a_fall_ok, b_rise_ok, c_rise_ok;

    always_comb begin
        a_fall_ok = a_prv & ~a_cur & b_cur;
        b_rise_ok = ~b_prv & b_cur & ~a_cur;
        c_rise_ok = ~c_prv & ~a_cur & b_cur;
        fire      = c_cur & (a_fall_ok | b_rise_ok | c_rise_ok);
    end
endmodule

// File: rtl/os_channel.sv
module os_channel
    import oneshot_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          a_n,
    input  logic          b,
    input  logic [CW-1:0] len,
    output logic          q,
    output logic          q_n
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic          ch_rst_n;
    logic [1:0]    ab_cur, ab_prv;
    logic          c_cur, c_prv;
    logic          fire;
    logic [CW-1:0] len_eff;
    logic [CW-1:0] cnt, cnt_nx;
    os_state_e     state, state_nx;

    // clear asserts asynchronously; release is re-timed by the clear synchronizer
    assign ch_rst_n = rst_n & clr_n;

    // reset values chosen so no edge can be seen out of reset: a=0, b=1
    os_sync #(.W(2), .RST_VAL(2'b01)) u_ab_sync (
        .clk    (clk),
        .arst_n (rst_n),
        .d      ({a_n, b}),
        .cur    (ab_cur),
        .prev   (ab_prv)
    );

    os_sync #(.W(1), .RST_VAL(1'b0)) u_clr_sync (
        .clk    (clk),
        .arst_n (ch_rst_n),
        .d      (1'b1),
        .cur    (c_cur),
        .prev   (c_prv)
    );

    os_fire_gate u_gate (
        .a_cur (ab_cur[1]),
        .a_prv (ab_prv[1]),
        .b_cur (ab_cur[0]),
        .b_prv (ab_prv[0]),
        .c_cur (c_cur),
        .c_prv (c_prv),
        .fire  (fire)
    );

    assign len_eff = (len == '0) ? ONE : len;

    // state register
    always_ff @(posedge clk or negedge ch_rst_n) begin
        if (!ch_rst_n) begin
            state <= OS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            OS_IDLE: begin
                if (fire) begin
                    state_nx = OS_PULSE;
                    cnt_nx   = len_eff - ONE;
                end
            end
            OS_PULSE: begin
                if (fire) begin
                    cnt_nx = len_eff - ONE;
                end else if (cnt == '0) begin
                    state_nx = OS_IDLE;
                end else begin
                    cnt_nx = cnt - ONE;
                end
            end
            default: state_nx = OS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        q   = (state == OS_PULSE);
        q_n = ~q;
    end

    a_r1_a_fall_fires: assert property (@(posedge clk) disable iff (!ch_rst_n)
        (ab_prv[1] && !ab_cur[1] && ab_cur[0] && c_cur) |=> state == OS_PULSE);

    a_r2_b_rise_fires: assert property (@(posedge clk) disable iff (!ch_rst_n)
        (!ab_prv[0] && ab_cur[0] && !ab_cur[1] && c_cur) |=> state == OS_PULSE);

    a_r5_clear_holds_idle: assert property (@(posedge clk) disable iff (!ch_rst_n)
        !c_cur |-> state == OS_IDLE);

    a_r6_clear_rise_fires: assert property (@(posedge clk) disable iff (!ch_rst_n)
        (c_cur && !c_prv && !ab_cur[1] && ab_cur[0]) |=> state == OS_PULSE);

    a_r7_expire: assert property (@(posedge clk) disable iff (!ch_rst_n)
        (state == OS_PULSE && !fire && cnt == '0) |=> state == OS_IDLE);

    a_r7_tick: assert property (@(posedge clk) disable iff (!ch_rst_n)
        (state == OS_PULSE && !fire && cnt != '0) |=> cnt == CW'($past(cnt) - ONE));

    a_r8_full_reload: assert property (@(posedge clk) disable iff (!ch_rst_n)
        fire |=> (state == OS_PULSE && cnt == CW'($past(len_eff) - ONE)));
endmodule

// File: rtl/os_pair.sv
module os_pair #(
    parameter int NCH = 2,
    parameter int CW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          clr_n,
    input  logic [NCH-1:0]          trig_a_n,
    input  logic [NCH-1:0]          trig_b,
    input  logic [NCH-1:0][CW-1:0]  pulse_len,
    output logic [NCH-1:0]          q,
    output logic [NCH-1:0]          q_n
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        os_channel #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_n (clr_n[i]),
            .a_n   (trig_a_n[i]),
            .b     (trig_b[i]),
            .len   (pulse_len[i]),
            .q     (q[i]),
            .q_n   (q_n[i])
        );
    end
endmodule

// File: tb/tb_os_pair.sv
module tb_os_pair;
    localparam int CLK_P = 10;
    localparam int NCH   = 2;
    localparam int CW    = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [NCH-1:0]         clr_n, trig_a_n, trig_b;
    logic [NCH-1:0][CW-1:0] pulse_len;
    logic [NCH-1:0]         q, q_n;

    int n_chk = 0;
    int n_bad = 0;

    os_pair #(.NCH(NCH), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .trig_a_n(trig_a_n),
        .trig_b(trig_b), .pulse_len(pulse_len), .q(q), .q_n(q_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // wait until the sample point where a trigger driven now becomes visible on q
    task automatic wait_latency();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // count cycles with q high, starting at the current negedge; watch complement and other channel
    task automatic measure(input int ch, output int n, output bit other_hi, output bit comp_bad);
        n = 0; other_hi = 0; comp_bad = 0;
        while (q[ch] && n < 200) begin
            if (q_n[ch] !== ~q[ch]) comp_bad = 1;
            if (q[1-ch]) other_hi = 1;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int  n;
        bit  oh, cb;
        rst_n = 0; clr_n = '1; trig_a_n = '1; trig_b = '1;
        pulse_len = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(q == '0, "R11 reset q", int'(q), 0);
        check(q_n == '1, "R11 reset q_n", int'(q_n), 3);
        rst_n = 1;
        repeat (6) @(negedge clk);
        check(q == '0, "R6 release with a high does not fire", int'(q), 0);

        // R7/R1/R10 sweep of every length on both channels
        for (int ch = 0; ch < NCH; ch++) begin
            for (int len = 0; len < (1 << CW); len++) begin
                pulse_len[ch] = CW'(len);
                trig_a_n[ch] = 1; trig_b[ch] = 1;
                repeat (4) @(negedge clk);
                trig_a_n[ch] = 0;
                wait_latency();
                check(q[ch] == 1, "R1 a fall fires", int'(q[ch]), 1);
                measure(ch, n, oh, cb);
                check(n == ((len == 0) ? 1 : len), "R7 pulse length", n, (len == 0) ? 1 : len);
                check(!oh, "R10 other channel quiet", int'(oh), 0);
                check(!cb, "R11 complement", int'(cb), 0);
                trig_a_n[ch] = 1;
            end
        end

        // R1/R2/R3 all before/after level pairs on channel 0
        pulse_len[0] = 4'd2;
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 4; e++) begin
                bit exp_f;
                trig_a_n[0] = s[1]; trig_b[0] = s[0];
                repeat (12) @(negedge clk);
                trig_a_n[0] = e[1]; trig_b[0] = e[0];
                wait_latency();
                exp_f = (s[1] & ~e[1] & e[0]) | (~s[0] & e[0] & ~e[1]);
                check(q[0] == exp_f, exp_f ? "R1 R2 gated fire" : "R3 inhibit or no edge",
                      int'(q[0]), int'(exp_f));
            end
        end

        // R8 retrigger on channel 1 via b
        pulse_len[1] = 4'd10;
        trig_a_n[1] = 0; trig_b[1] = 0;
        repeat (6) @(negedge clk);
        trig_b[1] = 1;
        wait_latency();
        n = 0;
        while (q[1] && n < 200) begin
            if (n == 4) trig_b[1] = 0;
            if (n == 5) trig_b[1] = 1;
            n++;
            @(negedge clk);
        end
        check(n == 18, "R8 retrigger extends", n, 18);

        // R9 length change mid-pulse
        trig_b[1] = 0;
        repeat (4) @(negedge clk);
        trig_b[1] = 1;
        wait_latency();
        n = 0;
        while (q[1] && n < 200) begin
            if (n == 2) pulse_len[1] = 4'd3;
            n++;
            @(negedge clk);
        end
        check(n == 10, "R9 current pulse keeps length", n, 10);
        trig_b[1] = 0;
        repeat (4) @(negedge clk);
        trig_b[1] = 1;
        wait_latency();
        measure(1, n, oh, cb);
        check(n == 3, "R9 new length on next trigger", n, 3);

        // R4 asynchronous clear mid-pulse
        pulse_len[0] = 4'd15;
        trig_a_n[0] = 1; trig_b[0] = 1;
        repeat (4) @(negedge clk);
        trig_a_n[0] = 0;
        wait_latency();
        repeat (3) @(negedge clk);
        check(q[0] == 1, "R4 pulse running before clear", int'(q[0]), 1);
        #1 clr_n[0] = 0;
        #1;
        check(q[0] == 0, "R4 clear drops q at once", int'(q[0]), 0);
        check(q_n[0] == 1, "R4 clear raises q_n at once", int'(q_n[0]), 1);

        // R5 triggers ignored while clear low
        @(negedge clk);
        trig_a_n[0] = 1;
        repeat (3) @(negedge clk);
        trig_a_n[0] = 0;
        oh = 0;
        repeat (8) begin
            @(negedge clk);
            if (q[0]) oh = 1;
        end
        check(!oh, "R5 trigger ignored under clear", int'(oh), 0);

        // R6 clear release with a low, b high fires
        @(negedge clk);
        clr_n[0] = 1;
        wait_latency();
        check(q[0] == 1, "R6 clear release fires", int'(q[0]), 1);
        measure(0, n, oh, cb);
        check(n == 15, "R6 clear-fired length", n, 15);
        check(!oh, "R10 other channel quiet", int'(oh), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule